// File: doc/BRIEF.md
# UART Receive Buffer Descriptor Engine

This block sits behind a UART deserializer. It takes each received character, which arrives with its error flags, and stores it into a ring of receive buffer descriptors held in a small local memory. Each descriptor holds four control flags, three error status bits, a byte count and a fixed-size data area. Software prepares the flags through a host port. It marks a descriptor empty when the hardware may fill it, and it asks for an interrupt, a continuous reuse or a return to the start of the ring.

After the receiver is enabled, the engine hunts until the first character arrives. It then fills the descriptor under its pointer, one byte at a time. A buffer is closed when it is full, or when an optional idle timer counts a programmed number of idle character times with no new character. Closing hands the descriptor back to software unless it is in continuous mode, pulses the interrupt if the descriptor asked for one, and moves the pointer on. Characters that find no empty descriptor are dropped and a busy flag is raised.

Top module: `rxbd_engine`

## Requirements
- R1: After reset every descriptor word and every data byte reads 0, and `irqPulse` and `busyFlag` are 0.
- R2: While `rxEnable` is 0, characters are ignored, the pointer is held at descriptor 0 and the engine hunts. The first character after enable goes to descriptor 0.
- R3: A character is stored only into the descriptor under the pointer, and only if its empty flag (word bit 0) is set. Bytes go to positions 0, 1, 2 and so on, and the count field (word bits 15:8) equals the number of bytes stored.
- R4: Storing the last byte (position BUF_BYTES-1) closes the buffer. The next character goes to the next descriptor.
- R5: `irqPulse` is high for exactly the one cycle after a close, and only if the closed descriptor's interrupt flag (bit 1) is set.
- R6: With `maxIdle` nonzero, `maxIdle` consecutive `idleTick` pulses without a character close a buffer holding at least one byte. Each character reloads the timer. A value of 0 disables the timer, and an empty buffer is never closed by the timer.
- R7: On close, the empty flag is cleared unless the continuous flag (bit 2) is set. A continuous descriptor is overwritten from position 0 on the next pass.
- R8: After a close, the pointer returns to 0 if the wrap flag (bit 3) is set or the descriptor was the last one. Otherwise it advances by one.
- R9: The overrun, parity and framing flags of the stored characters are ORed into bits 4, 5 and 6 of the descriptor being filled. They are cleared when its first byte is stored.
- R10: A character that arrives while the current descriptor is not empty is dropped, and `busyFlag` rises the next cycle. `busyFlag` falls the cycle after the current descriptor is empty again.
- R11: A host write to a descriptor word (`hostAddr[5]`=0) loads flag bits 3:0 from `hostWrData` and clears the count and status. A host read returns the word, or the data byte zero-extended when `hostAddr[5]`=1 (`hostAddr[4:2]` selects the descriptor and `hostAddr[1:0]` the byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable; low returns the engine to hunt |
| rxValid | input | 1 | One received character this cycle |
| rxData | input | 8 | Received character |
| rxOverrunErr | input | 1 | Overrun flag for this character |
| rxParityErr | input | 1 | Parity error flag for this character |
| rxFrameErr | input | 1 | Framing error flag for this character |
| idleTick | input | 1 | One pulse per idle character time on the line |
| maxIdle | input | 16 | Idle character times before a close; 0 disables |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 6 | {data select, descriptor, byte} |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 16 | Host read data (combinational) |
| irqPulse | output | 1 | One-cycle interrupt on a close |
| busyFlag | output | 1 | Characters are being dropped |

## Verification
Full buffers, short bursts closed by the idle timer, and bursts broken by gaps shorter than the timeout are each sent. These separate a close on count from a close on timeout, and show that each character reloads the timer. Characters that meet a descriptor owned by software show the drop path and the release of the busy flag. A run of more than one full lap around the ring shows the difference between the explicit wrap flag and the natural end of the ring. Error flags placed on the first and on later bytes show accumulation within a buffer, and clearing when a continuous descriptor is refilled.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // Descriptor flag nibble, empty is bit 0
  typedef struct packed {
    logic wrap;
    logic cont;
    logic intr;
    logic empty;
  } bd_flags_t;

  // Error status, overrun is the low bit
  typedef struct packed {
    logic framing;
    logic parity;
    logic overrun;
  } bd_err_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic store;   // write current character
    logic close;   // close current descriptor
    logic first;   // first byte of this buffer
  } rxbd_strb_t;

  typedef enum logic {ST_HUNT, ST_RUN} rxbd_state_e;

  localparam int CNT_W = 8;
  localparam int WORD_W = 16;

endpackage

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int BUF_BYTES = 4,
  parameter int IDLE_W = 16,
  parameter int BD_W = $clog2(NUM_BD),
  parameter int POS_W = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              rxValid,
  input  logic              idleTick,
  input  logic [IDLE_W-1:0] maxIdle,
  input  bd_flags_t         curFlags,
  output rxbd_strb_t        strb,
  output logic [BD_W-1:0]   bdIdx,
  output logic [POS_W-1:0]  bytePos,
  output logic              irqPulse,
  output logic              busyFlag
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BUF_BYTES - 1);
  localparam logic [BD_W-1:0]  LAST_BD  = BD_W'(NUM_BD - 1);

  rxbd_state_e      state;
  logic [BD_W-1:0]  ptr;
  logic [POS_W-1:0] fillPos;
  logic [IDLE_W-1:0] idleCnt;

  logic charIn, take, drop, full, idleEn, tickCount, idleExpire, closeNow;
  logic [BD_W-1:0] nextPtr;

  always_comb begin
    charIn     = rxEnable && rxValid;
    take       = charIn && curFlags.empty;
    drop       = charIn && !curFlags.empty;
    full       = take && (fillPos == LAST_POS);
    idleEn     = (maxIdle != '0);
    tickCount  = !charIn && idleTick && idleEn && (state == ST_RUN) && (fillPos != '0);
    idleExpire = tickCount && (idleCnt >= maxIdle - IDLE_W'(1));
    closeNow   = full || idleExpire;
    nextPtr    = (curFlags.wrap || ptr == LAST_BD) ? '0 : ptr + BD_W'(1);
  end

  assign strb.store  = take;
  assign strb.close  = closeNow;
  assign strb.first  = (fillPos == '0);
  assign bdIdx       = ptr;
  assign bytePos     = fillPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      ptr      <= '0;
      fillPos  <= '0;
      idleCnt  <= '0;
      busyFlag <= 1'b0;
      irqPulse <= 1'b0;
    end else if (!rxEnable) begin
      state    <= ST_HUNT;
      ptr      <= '0;
      fillPos  <= '0;
      idleCnt  <= '0;
      busyFlag <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (charIn) state <= ST_RUN;
      irqPulse <= closeNow && curFlags.intr;
      if (closeNow) begin
        ptr     <= nextPtr;
        fillPos <= '0;
      end else if (take) begin
        fillPos <= fillPos + POS_W'(1);
      end
      if (charIn || closeNow) idleCnt <= '0;
      else if (tickCount)     idleCnt <= idleCnt + IDLE_W'(1);
      if (drop)                busyFlag <= 1'b1;
      else if (curFlags.empty) busyFlag <= 1'b0;
    end
  end

  // R10: a dropped character raises busy on the next cycle
  a_r10_drop_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && rxValid && !curFlags.empty |=> busyFlag);

  // R8: wrap flag on the closing descriptor sends the pointer to 0
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.close && curFlags.wrap |=> bdIdx == '0);

  // R6: a close without a store only happens on a partly filled buffer
  a_r6_idle_needs_bytes: assert property (@(posedge clk) disable iff (!rstN)
    strb.close && !strb.store |-> bytePos != '0 && idleTick);

  // R5: interrupt only after a close of a descriptor that asked for it
  a_r5_irq_needs_close: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(strb.close) && $past(curFlags.intr));

endmodule

// File: rtl/rxbd_dpath.sv
module rxbd_dpath
  import rxbd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int BUF_BYTES = 4,
  parameter int BD_W = $clog2(NUM_BD),
  parameter int POS_W = $clog2(BUF_BYTES),
  parameter int ADDR_W = 1 + BD_W + POS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxbd_strb_t        strb,
  input  logic [BD_W-1:0]   bdIdx,
  input  logic [POS_W-1:0]  bytePos,
  input  logic [7:0]        rxData,
  input  bd_err_t           rxErr,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output bd_flags_t         curFlags
);

  localparam int IDX_W  = BD_W + POS_W;
  localparam int DATA_N = NUM_BD * BUF_BYTES;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BUF_BYTES - 1);

  bd_flags_t        flagMem [NUM_BD];
  bd_err_t          errMem  [NUM_BD];
  logic [CNT_W-1:0] cntMem  [NUM_BD];
  logic [7:0]       dataMem [DATA_N];

  logic             hostIsData;
  logic [BD_W-1:0]  hostBd;
  logic [IDX_W-1:0] hostIdx;
  logic [IDX_W-1:0] engIdx;
  logic             hostCtrlWr, hostDataWr;

  assign hostIsData = hostAddr[ADDR_W-1];
  assign hostBd     = hostAddr[POS_W +: BD_W];
  assign hostIdx    = hostAddr[IDX_W-1:0];
  assign engIdx     = {bdIdx, bytePos};
  assign hostCtrlWr = hostWrEn && !hostIsData;
  assign hostDataWr = hostWrEn && hostIsData;
  assign curFlags   = flagMem[bdIdx];

  // Descriptor words; a host write wins over the engine on the same entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_BD; g++) begin
        flagMem[g] <= '0;
        errMem[g]  <= '0;
        cntMem[g]  <= '0;
      end
    end else begin
      for (int g = 0; g < NUM_BD; g++) begin
        if (hostCtrlWr && hostBd == BD_W'(g)) begin
          flagMem[g] <= bd_flags_t'(hostWrData[3:0]);
          errMem[g]  <= '0;
          cntMem[g]  <= '0;
        end else if (bdIdx == BD_W'(g)) begin
          if (strb.store) begin
            cntMem[g] <= CNT_W'(bytePos) + CNT_W'(1);
            errMem[g] <= strb.first ? rxErr : (errMem[g] | rxErr);
          end
          if (strb.close && !flagMem[g].cont) flagMem[g].empty <= 1'b0;
        end
      end
    end
  end

  // Data bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DATA_N; i++) dataMem[i] <= '0;
    end else begin
      for (int i = 0; i < DATA_N; i++) begin
        if (hostDataWr && hostIdx == IDX_W'(i))
          dataMem[i] <= hostWrData;
        else if (strb.store && engIdx == IDX_W'(i))
          dataMem[i] <= rxData;
      end
    end
  end

  always_comb begin
    if (hostIsData)
      hostRdData = {8'h00, dataMem[hostIdx]};
    else
      hostRdData = {cntMem[hostBd], 1'b0, errMem[hostBd], flagMem[hostBd]};
  end

  // R3: the count follows the byte just stored
  a_r3_count_tracks: assert property (@(posedge clk) disable iff (!rstN)
    strb.store && !(hostCtrlWr && hostBd == bdIdx)
    |=> cntMem[$past(bdIdx)] == CNT_W'($past(bytePos)) + CNT_W'(1));

  // R4: storing into the last position closes the buffer
  a_r4_full_closes: assert property (@(posedge clk) disable iff (!rstN)
    strb.store && bytePos == LAST_POS |-> strb.close);

  // R7: a continuous descriptor stays owned by the engine after a close
  a_r7_cont_keeps_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.close && curFlags.cont && curFlags.empty && !(hostCtrlWr && hostBd == bdIdx)
    |=> flagMem[$past(bdIdx)].empty);

endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int BUF_BYTES = 4,
  parameter int IDLE_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           rxEnable,
  input  logic                           rxValid,
  input  logic [7:0]                     rxData,
  input  logic                           rxOverrunErr,
  input  logic                           rxParityErr,
  input  logic                           rxFrameErr,
  input  logic                           idleTick,
  input  logic [IDLE_W-1:0]              maxIdle,
  input  logic                           hostWrEn,
  input  logic [$clog2(NUM_BD)+$clog2(BUF_BYTES):0] hostAddr,
  input  logic [7:0]                     hostWrData,
  output logic [15:0]                    hostRdData,
  output logic                           irqPulse,
  output logic                           busyFlag
);

  localparam int BD_W   = $clog2(NUM_BD);
  localparam int POS_W  = $clog2(BUF_BYTES);
  localparam int ADDR_W = 1 + BD_W + POS_W;

  rxbd_strb_t       strb;
  bd_flags_t        curFlags;
  bd_err_t          rxErr;
  logic [BD_W-1:0]  bdIdx;
  logic [POS_W-1:0] bytePos;

  assign rxErr = '{framing: rxFrameErr, parity: rxParityErr, overrun: rxOverrunErr};

  rxbd_ctrl #(
    .NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES), .IDLE_W(IDLE_W),
    .BD_W(BD_W), .POS_W(POS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rxValid(rxValid),
    .idleTick(idleTick), .maxIdle(maxIdle), .curFlags(curFlags),
    .strb(strb), .bdIdx(bdIdx), .bytePos(bytePos),
    .irqPulse(irqPulse), .busyFlag(busyFlag)
  );

  rxbd_dpath #(
    .NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES),
    .BD_W(BD_W), .POS_W(POS_W), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .bdIdx(bdIdx), .bytePos(bytePos),
    .rxData(rxData), .rxErr(rxErr), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .curFlags(curFlags)
  );

endmodule

// File: tb/rxbd_engine_tb.sv
`timescale 1ns/1ps
module rxbd_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0, rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxOverrunErr = 1'b0, rxParityErr = 1'b0, rxFrameErr = 1'b0;
  logic        idleTick = 1'b0;
  logic [15:0] maxIdle = '0;
  logic        hostWrEn = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic [15:0] hostRdData;
  logic        irqPulse, busyFlag;

  rxbd_engine u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rxValid(rxValid), .rxData(rxData),
    .rxOverrunErr(rxOverrunErr), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .idleTick(idleTick), .maxIdle(maxIdle), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irqPulse(irqPulse), .busyFlag(busyFlag)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Reference model state
  int mFlags[8], mErr[8], mCnt[8], mData[32];
  int mPtr = 0, mFill = 0, mIdle = 0, mBusy = 0, mIrq = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance the model by one clock with the inputs currently driven
  task automatic modelStep();
    int curE, curI, curC, curW, errIn, closeNow, nBusy, nIrq;
    closeNow = 0; nIrq = 0;
    if (!rxEnable) begin
      mPtr = 0; mFill = 0; mIdle = 0; mBusy = 0; mIrq = 0;
    end else begin
      curE = mFlags[mPtr] & 1;       curI = (mFlags[mPtr] >> 1) & 1;
      curC = (mFlags[mPtr] >> 2) & 1; curW = (mFlags[mPtr] >> 3) & 1;
      errIn = {rxFrameErr, rxParityErr, rxOverrunErr};
      nBusy = curE ? 0 : mBusy;
      if (rxValid) begin
        mIdle = 0;
        if (curE) begin
          mData[mPtr*4 + mFill] = rxData;
          mErr[mPtr] = (mFill == 0) ? errIn : (mErr[mPtr] | errIn);
          mCnt[mPtr] = mFill + 1;
          if (mFill == 3) closeNow = 1; else mFill++;
        end else nBusy = 1;
      end else if (idleTick && maxIdle != 0 && mFill != 0) begin
        if (mIdle + 1 >= maxIdle) closeNow = 1; else mIdle++;
      end
      if (closeNow) begin
        if (!curC) mFlags[mPtr] &= ~1;
        nIrq = curI;
        mPtr = (curW || mPtr == 7) ? 0 : mPtr + 1;
        mFill = 0; mIdle = 0;
      end
      mBusy = nBusy; mIrq = nIrq;
    end
    if (hostWrEn) begin
      if (!hostAddr[5]) begin
        mFlags[hostAddr[4:2]] = hostWrData[3:0];
        mErr[hostAddr[4:2]] = 0; mCnt[hostAddr[4:2]] = 0;
      end else mData[hostAddr[4:0]] = hostWrData;
    end
  endtask

  // One clock: model, edge, compare outputs at the falling edge
  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check("R5 irqPulse", irqPulse, mIrq);
    check("R10 busyFlag", busyFlag, mBusy);
    rxValid = 0; idleTick = 0; hostWrEn = 0;
    {rxFrameErr, rxParityErr, rxOverrunErr} = 3'b000;
  endtask

  task automatic sendChar(logic [7:0] d, logic [2:0] err = 3'b000);
    rxValid = 1; rxData = d; {rxFrameErr, rxParityErr, rxOverrunErr} = err;
    cyc();
  endtask

  task automatic tick();
    idleTick = 1; cyc();
  endtask

  task automatic hostWrite(int bd, logic [3:0] flags);
    hostWrEn = 1; hostAddr = {1'b0, 3'(bd), 2'b00}; hostWrData = {4'h0, flags};
    cyc();
  endtask

  task automatic readCtrl(string tag, int bd, int exp);
    hostAddr = {1'b0, 3'(bd), 2'b00}; #1;
    check(tag, hostRdData, exp);
  endtask

  task automatic readData(string tag, int bd, int pos, int exp);
    hostAddr = {1'b1, 3'(bd), 2'(pos)}; #1;
    check(tag, hostRdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mFlags[i] = 0; mErr[i] = 0; mCnt[i] = 0; end
    for (int i = 0; i < 32; i++) mData[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    check("R1 irqPulse", irqPulse, 0);
    check("R1 busyFlag", busyFlag, 0);
    for (int b = 0; b < 8; b++) readCtrl("R1 word", b, 0);
    readData("R1 data", 5, 3, 0);

    // R2: characters ignored while disabled
    hostWrite(0, 4'b0001);
    sendChar(8'hAA); sendChar(8'hAB);
    readCtrl("R2 disabled", 0, 16'h0001);

    hostWrite(0, 4'b0011); hostWrite(1, 4'b0001);
    hostWrite(2, 4'b0111); hostWrite(3, 4'b1011);
    maxIdle = 3;
    rxEnable = 1;
    tick(); tick();              // hunting, nothing to close
    readCtrl("R2 hunt", 0, 16'h0003);

    // R3, R4, R5: fill bd0
    sendChar(8'h11); sendChar(8'h22); sendChar(8'h33); sendChar(8'h44);
    readCtrl("R4 full close", 0, 16'h0402);
    readData("R3 byte0", 0, 0, 8'h11);
    readData("R3 byte3", 0, 3, 8'h44);

    // R6, R9: short burst closed by idle, parity on second byte
    sendChar(8'h55); sendChar(8'h66, 3'b010);
    tick(); tick(); tick();
    readCtrl("R9 parity status", 1, 16'h0220);

    // R11: host write clears count and status
    hostWrite(1, 4'b0001);
    readCtrl("R11 host write", 1, 16'h0001);

    // R6 reload, R7 continuous
    sendChar(8'h77); tick(); tick(); sendChar(8'h88); tick(); tick();
    readCtrl("R6 reload no close", 2, 16'h0207);
    tick();
    readCtrl("R7 cont kept", 2, 16'h0207);

    // R8 wrap, R9 overrun
    sendChar(8'h99, 3'b001); sendChar(8'hA0); sendChar(8'hB0); sendChar(8'hC0);
    readCtrl("R8 R9 bd3", 3, 16'h041A);

    // R10: drop into closed bd0
    sendChar(8'hD0);
    readCtrl("R10 dropped", 0, 16'h0402);
    tick(); cyc();
    hostWrite(0, 4'b0001);
    cyc();
    sendChar(8'hE0);
    readCtrl("R10 after release", 0, 16'h0101);
    sendChar(8'hE1); sendChar(8'hE2); sendChar(8'hE3);
    sendChar(8'hF0); tick(); tick(); tick();
    // R7: continuous bd2 refilled from position 0
    sendChar(8'h12);
    readCtrl("R7 refill", 2, 16'h0107);
    readData("R7 refill byte", 2, 0, 8'h12);
    tick(); tick(); tick();

    // R6: timer disabled
    hostWrite(3, 4'b0001);
    maxIdle = 0;
    sendChar(8'h34);
    for (int i = 0; i < 6; i++) tick();
    readCtrl("R6 disabled", 3, 16'h0101);

    // R2: disable returns pointer to 0
    rxEnable = 0; cyc();
    hostWrite(0, 4'b0001);
    rxEnable = 1;
    sendChar(8'h56);
    readCtrl("R2 restart", 0, 16'h0101);
    readData("R2 restart byte", 0, 0, 8'h56);

    // R8: natural end of ring
    rxEnable = 0; cyc();
    for (int b = 0; b < 8; b++) hostWrite(b, 4'b0001);
    rxEnable = 1;
    for (int i = 0; i < 33; i++) begin
      if (i == 32) hostWrite(0, 4'b0001);
      sendChar(8'(i));
    end
    readCtrl("R8 lap", 0, 16'h0101);
    readData("R8 lap byte", 0, 0, 32);
    readCtrl("R8 last bd", 7, 16'h0400);

    // R3: full sweep against the model
    for (int b = 0; b < 8; b++) begin
      readCtrl("R3 sweep word", b, (mCnt[b] << 8) | (mErr[b] << 4) | mFlags[b]);
      for (int p = 0; p < 4; p++) readData("R3 sweep data", b, p, mData[b*4 + p]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule